// File: doc/BRIEF.md
# Parallel-Access Shift Register with J/K-bar Serial Entry

This block is a small synchronous register of four stages with two operating modes chosen by an active-low mode input. With the mode input high the register shifts by one position per rising clock edge, moving each stage's value into the next higher stage. Stage 0 takes a new value formed from a J input and an inverted-K input. With the mode input low, all stages capture the parallel data inputs at once on the rising edge.

The J/K-bar pair lets stage 0 be set, cleared, toggled or held during a shift. Tying the two inputs together turns the pair into a plain serial data input. A shift toward stage 0 is obtained outside the block by wiring each stage output back to the parallel input one position lower and holding the mode input low. Besides the stage values, the block drives the complement of the last stage. An active-low master reset clears every stage at once, without waiting for a clock edge.

Top module: `pa_shift_reg`

## Requirements
- R1: While `rst_n` is low, all bits of `q_out` are 0 and `q_last_n` is 1, and this takes effect at once without a clock edge.
- R2: With `rst_n` high and `load_n` high (shift mode), a rising edge moves `q_out[i]` into `q_out[i+1]` for i = 0..2.
- R3: With `rst_n` high and `load_n` low (load mode), a rising edge copies `par_in[i]` into `q_out[i]` for every i.
- R4: In shift mode with `j_in`=1 and `k_n_in`=1, stage 0 becomes 1.
- R5: In shift mode with `j_in`=0 and `k_n_in`=0, stage 0 becomes 0.
- R6: In shift mode with `j_in`=1 and `k_n_in`=0, stage 0 becomes the inverse of its previous value.
- R7: In shift mode with `j_in`=0 and `k_n_in`=1, stage 0 keeps its previous value.
- R8: `q_last_n` is always the inverse of `q_out[3]`.
- R9: In load mode, `j_in` and `k_n_in` have no effect on the captured value.
- R10: Driving `par_in[i]` from `q_out[i+1]` (i = 0..2) and a fill bit into `par_in[3]` with `load_n` low moves data from stage 3 toward stage 0 by one position per edge.
- R11: With `j_in` and `k_n_in` driven by the same bit, a shift stores that bit in stage 0.
- R12: The first rising edge after `rst_n` returns high performs a normal load or shift.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous master reset |
| load_n | input | 1 | Mode select: low loads `par_in`, high shifts |
| j_in | input | 1 | J input for stage 0 in shift mode |
| k_n_in | input | 1 | Inverted-K input for stage 0 in shift mode |
| par_in | input | 4 | Parallel data, bit i goes to stage i |
| q_out | output | 4 | Stage values, bit i is stage i |
| q_last_n | output | 1 | Complement of stage 3 |

## Verification
A wrong stage value reaches `q_out` on the same edge that creates it, so a bench comparing every output after every edge sees it within one cycle. A fault in the stage-0 entry logic shows only when a shift runs, and each J/K-bar combination must be run against both stage-0 values to show it. A corrupted shift path reaches `q_last_n` up to three edges later, once the bad bit arrives in stage 3. A reset fault shows between clock edges, so the reset value is sampled with no edge in between.

// File: rtl/psr_pkg.sv
// Package: shared types for the parallel-access shift register.
// Assumes: a one-bit mode select, low meaning load.
package psr_pkg;
    typedef enum logic {
        MODE_LOAD  = 1'b0,
        MODE_SHIFT = 1'b1
    } psr_mode_e;
endpackage

// File: rtl/psr_entry_logic.sv
// Module: psr_entry_logic
// Forms the next value of stage 0 during a shift from the J and inverted-K
// inputs and the present stage-0 value.
// Assumes: pure combinational, used only when the register shifts.
module psr_entry_logic (
    input  logic j_in,
    input  logic k_n_in,
    input  logic cur_bit,
    output logic next_bit
);
    // Set when J is high and the stage is 0; keep when K-bar is high and the stage is 1.
    always_comb begin
        next_bit = (j_in & ~cur_bit) | (k_n_in & cur_bit);
    end
endmodule

// File: rtl/psr_stage_mux.sv
// Module: psr_stage_mux
// Picks the next value of every stage: parallel data in load mode, the lower
// neighbour (or the entry bit for stage 0) in shift mode.
// Assumes: WIDTH >= 2.
module psr_stage_mux
    import psr_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  psr_mode_e          mode,
    input  logic [WIDTH-1:0]   par_in,
    input  logic [WIDTH-1:0]   cur_q,
    input  logic               entry_bit,
    output logic [WIDTH-1:0]   next_q
);
    genvar gi;
    generate
        for (gi = 0; gi < WIDTH; gi++) begin : g_stage
            if (gi == 0) begin : g_first
                // Stage 0 takes the entry bit when shifting.
                always_comb begin
                    next_q[gi] = (mode == MODE_LOAD) ? par_in[gi] : entry_bit;
                end
            end else begin : g_rest
                // Higher stages take the lower neighbour when shifting.
                always_comb begin
                    next_q[gi] = (mode == MODE_LOAD) ? par_in[gi] : cur_q[gi-1];
                end
            end
        end
    endgenerate
endmodule

// File: rtl/pa_shift_reg.sv
// Module: pa_shift_reg
// Four-stage parallel-access shift register with J/K-bar entry on stage 0,
// active-low load select and a complemented last-stage output.
// Assumes: master reset acts asynchronously; its release is not synchronized
// here and takes effect from the next rising clock edge.
module pa_shift_reg
    import psr_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_n,
    input  logic             j_in,
    input  logic             k_n_in,
    input  logic [WIDTH-1:0] par_in,
    output logic [WIDTH-1:0] q_out,
    output logic             q_last_n
);
    localparam int LAST = WIDTH - 1;

    psr_mode_e        mode;
    logic             entry_bit;
    logic [WIDTH-1:0] stage_q;
    logic [WIDTH-1:0] stage_d;

    // Decode the mode select into the shared mode type.
    always_comb begin
        mode = psr_mode_e'(load_n);
    end

    psr_entry_logic u_entry (
        .j_in     (j_in),
        .k_n_in   (k_n_in),
        .cur_bit  (stage_q[0]),
        .next_bit (entry_bit)
    );

    psr_stage_mux #(.WIDTH(WIDTH)) u_mux (
        .mode      (mode),
        .par_in    (par_in),
        .cur_q     (stage_q),
        .entry_bit (entry_bit),
        .next_q    (stage_d)
    );

    // Stage register: cleared at once by master reset, else updated per edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q <= stage_d;
        end
    end

    // Drive the stage outputs and the complemented last stage.
    always_comb begin
        q_out    = stage_q;
        q_last_n = ~stage_q[LAST];
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |-> (q_out == '0 && q_last_n == 1'b1));

    // R2
    shift_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_n |=> q_out[WIDTH-1:1] == $past(q_out[WIDTH-2:0]));

    // R3
    load_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_n |=> q_out == $past(par_in));

    // R4
    entry_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && j_in && k_n_in) |=> q_out[0]);

    // R5
    entry_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && !j_in && !k_n_in) |=> !q_out[0]);

    // R6
    entry_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && j_in && !k_n_in) |=> q_out[0] != $past(q_out[0]));

    // R7
    entry_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && !j_in && k_n_in) |=> q_out[0] == $past(q_out[0]));
endmodule

// File: tb/pa_shift_reg_bench.sv
module pa_shift_reg_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       load_n = 1'b1;
    logic       j_in = 1'b0;
    logic       k_n_in = 1'b0;
    logic [3:0] par_stim = 4'h0;
    logic       sl_mode = 1'b0;
    logic       sl_fill = 1'b0;
    logic [3:0] par_in;
    logic [3:0] q_out;
    logic       q_last_n;

    int vectors = 0;
    int errors  = 0;
    bit done    = 0;
    logic [3:0] model = 4'h0;

    always #2 clk = ~clk;

    // Shift-left wiring: each stage feeds the parallel input one below it.
    assign par_in = sl_mode ? {sl_fill, q_out[3:1]} : par_stim;

    pa_shift_reg u_pa_shift_reg (
        .clk(clk), .rst_n(rst_n), .load_n(load_n), .j_in(j_in),
        .k_n_in(k_n_in), .par_in(par_in), .q_out(q_out), .q_last_n(q_last_n)
    );

    task automatic compare(input string tag);
        vectors++;
        if (q_out !== model) begin
            errors++;
            $display("FAIL %s q_out actual=%b expected=%b", tag, q_out, model);
        end
        if (q_last_n !== ~model[3]) begin
            errors++;
            $display("FAIL R8 (%s) q_last_n actual=%b expected=%b", tag, q_last_n, ~model[3]);
        end
    endtask

    // Reference update: behavioural description of one rising edge.
    task automatic model_edge();
        logic [3:0] p;
        p = par_in;
        if (!rst_n) model = 4'h0;
        else if (sl_mode && !load_n) model = {sl_fill, model[3:1]};
        else if (!load_n) model = p;
        else begin
            logic b;
            case ({j_in, k_n_in})
                2'b11: b = 1'b1;
                2'b00: b = 1'b0;
                2'b10: b = ~model[0];
                default: b = model[0];
            endcase
            model = {model[2:0], b};
        end
    endtask

    // Drive inputs (caller is between edges), run one edge, compare after it.
    task automatic cyc(input logic ld_n, input logic j, input logic kn,
                       input logic [3:0] par, input string tag);
        load_n = ld_n; j_in = j; k_n_in = kn; par_stim = par;
        @(posedge clk);
        model_edge();
        #1;
        compare(tag);
        @(negedge clk);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state before any edge
        #1;
        compare("R1");
        @(negedge clk);
        cyc(1'b0, 1'b1, 1'b1, 4'hF, "R1");
        rst_n = 1'b1;
        // R12 / R3: first edge after release loads
        cyc(1'b0, 1'b0, 1'b0, 4'b1010, "R12");
        cyc(1'b0, 1'b0, 1'b0, 4'b0101, "R3");
        // R4..R7 against both stage-0 values
        cyc(1'b1, 1'b1, 1'b1, 4'h0, "R4");
        cyc(1'b1, 1'b1, 1'b1, 4'h0, "R4");
        cyc(1'b1, 1'b0, 1'b0, 4'h0, "R5");
        cyc(1'b1, 1'b0, 1'b0, 4'h0, "R5");
        cyc(1'b1, 1'b1, 1'b0, 4'h0, "R6");
        cyc(1'b1, 1'b1, 1'b0, 4'h0, "R6");
        cyc(1'b1, 1'b0, 1'b1, 4'h0, "R7");
        cyc(1'b1, 1'b1, 1'b0, 4'h0, "R6");
        cyc(1'b1, 1'b0, 1'b1, 4'h0, "R7");
        cyc(1'b1, 1'b0, 1'b0, 4'h0, "R2");
        // R9: J/K-bar ignored during load
        for (int i = 0; i < 4; i++)
            cyc(1'b0, i[0], i[1], 4'(4'h3 + 5 * i), "R9");
        // R11: J tied to K-bar acts as serial data
        for (int i = 0; i < 8; i++) begin
            logic b;
            b = ((8'b1011_0010 >> i) & 8'h1) != 0;
            cyc(1'b1, b, b, 4'h0, "R11");
        end
        // R2/R3 mixed random traffic
        for (int i = 0; i < 300; i++)
            cyc(($urandom % 4) != 0, 1'($urandom), 1'($urandom), 4'($urandom), "R2");
        // R10: shift toward stage 0 via external wiring
        cyc(1'b0, 1'b0, 1'b0, 4'b1011, "R3");
        sl_mode = 1'b1;
        sl_fill = 1'b0;
        for (int i = 0; i < 4; i++) cyc(1'b0, 1'b1, 1'b1, 4'h0, "R10");
        cyc(1'b0, 1'b0, 1'b0, 4'h0, "R3");
        sl_fill = 1'b1;
        for (int i = 0; i < 3; i++) cyc(1'b0, 1'b0, 1'b0, 4'h0, "R10");
        sl_mode = 1'b0;
        // R1: asynchronous clear between edges
        cyc(1'b0, 1'b0, 1'b0, 4'b1111, "R3");
        #0.5;
        rst_n = 1'b0;
        model = 4'h0;
        #0.5;
        compare("R1");
        cyc(1'b0, 1'b1, 1'b1, 4'b1111, "R1");
        rst_n = 1'b1;
        cyc(1'b1, 1'b1, 1'b1, 4'h0, "R12");
        cyc(1'b1, 1'b1, 1'b0, 4'h0, "R6");
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule